// File: doc/BRIEF.md
# Command FIFO Status Controller

This block is the device-side engine behind a byte-wide register window of a command/response coprocessor. A host first puts the device into its ready state through a status byte. It then pushes a command into a data FIFO one byte at a time and starts the command with a go bit. When the response is complete, the host pulls it back out through the same FIFO. The status byte shows whether more command bytes are expected and whether response bytes are waiting. A 16-bit burst count tells the host how many FIFO accesses it may make in a row.

The device learns how long a command is from the command itself: bytes 2 to 5 of the stream hold the total length, most significant byte first. Execution is delegated to an external engine. While the block is busy, the engine reads command bytes by index, streams response bytes back, and signals completion. A retry request replays the stored response from its first byte. Command and response share one buffer of `DEPTH` bytes (1024 by default).

Top module: `cmd_fifo_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80, both burst-count bytes read 0x00, and `exec_busy` is 0.
- R2: Register offsets are: status at 0x18, burst count low byte at 0x19, high byte at 0x1A, data FIFO at 0x24. The status bits are: bit 7 valid, which is 0 only while executing; bit 6 set in the ready state; bit 4 set while unread response bytes remain; bit 3 set while more command bytes are expected. All other bits read 0.
- R3: Writing a status byte with bit 6 set enters the ready state and discards any stored command and response. This works from every state except executing, where the write has no effect.
- R4: A FIFO write is stored only in the ready or receiving state, only while bit 3 is 1, and only while the buffer is not full. Any other FIFO write is dropped. The first stored byte moves the block from ready to receiving.
- R5: The command length is the big-endian 32-bit value in stream bytes 2..5. Bit 3 clears once at least 6 bytes have arrived and the byte count has reached that length. The length is presented on `exec_cmd_len`.
- R6: A status write with bit 5 set starts execution only in the receiving state with bit 3 clear. Otherwise it is ignored. Within one status write, bit 6 takes priority over bit 5, and bit 5 over bit 1.
- R7: While `exec_busy` is 1, `exec_rd_data` returns the command byte at `exec_rd_idx` in the same cycle. Each `rsp_we` appends `rsp_byte` to the response, overwriting the buffer from index 0, so the engine must read a command byte before it writes that index. `exec_done` moves the block to completion with the read position at the first response byte.
- R8: In completion, a FIFO read returns the next unread response byte and advances. A FIFO read with no unread bytes returns 0x00 and changes nothing.
- R9: A status write with bit 1 set in completion rewinds the read position to the first response byte. In any other state it is ignored.
- R10: The burst count reports three cases, saturating at 0xFFFF:
  - free buffer bytes while in ready or receiving with bit 3 set;
  - unread response bytes in completion;
  - 0 otherwise.
- R11: `bus_rdata` is a combinational function of `bus_addr` and the state, whatever the value of `bus_en`. Only an enabled FIFO read advances the response. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| exec_busy | output | 1 | High while the command is executing |
| exec_cmd_len | output | 32 | Command length taken from the stream |
| exec_rd_idx | input | IDX_W | Command byte index read by the engine |
| exec_rd_data | output | 8 | Command byte at `exec_rd_idx` |
| rsp_we | input | 1 | Append `rsp_byte` to the response |
| rsp_byte | input | 8 | Response byte |
| exec_done | input | 1 | Execution finished |

## Verification
The bench walks a full command through the block several times, each with a different stream:
- A normal ten-byte command followed by a seven-byte response, read partly, replayed and read out in full. This separates correct read-pointer handling from a pointer that is not rewound or not bounded.
- A stream whose declared length is shorter than the six header bytes. This shows that expect clears only once the length field itself has arrived.
- A stream whose declared length exceeds the buffer. Here the full-buffer drop and a zero burst coexist with expect still set.
- An aborted reception and an empty response. These check that ready really discards stored bytes and that the data flag is driven by the count rather than by the state.

Go, ready and retry writes are also issued in states where they must do nothing. A combined write with all three bits set exposes the priority order.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } cfs_state_e;

  // register window offsets
  localparam int OFF_STATUS   = 'h18;
  localparam int OFF_BURST_LO = 'h19;
  localparam int OFF_BURST_HI = 'h1A;
  localparam int OFF_FIFO     = 'h24;

  // status byte bit positions
  localparam int B_VALID  = 7;
  localparam int B_READY  = 6;
  localparam int B_GO     = 5;
  localparam int B_DATA   = 4;
  localparam int B_EXPECT = 3;
  localparam int B_RETRY  = 1;

  // position of the big-endian length field in the stream
  localparam int LEN_FIRST = 2;
  localparam int LEN_LAST  = 5;

endpackage

// File: rtl/cfs_len_track.sv
module cfs_len_track #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_we,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [7:0]       byte_data,
  output logic [31:0]      cmd_len,
  output logic             expect_more
);
  import cfs_pkg::*;

  logic [31:0] len_q, len_d;
  logic        len_en;
  logic        in_field;
  logic        hdr_seen;

  assign in_field = (byte_cnt >= CNT_W'(LEN_FIRST)) && (byte_cnt <= CNT_W'(LEN_LAST));
  assign len_en   = clr | (byte_we & in_field);

  always_comb begin
    if (clr) len_d = '0;
    else     len_d = {len_q[23:0], byte_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  assign hdr_seen    = byte_cnt > CNT_W'(LEN_LAST);
  assign expect_more = !(hdr_seen && (32'(byte_cnt) >= len_q));
  assign cmd_len     = len_q;

endmodule

// File: rtl/cfs_buf.sv
module cfs_buf #(
  parameter int DEPTH = 1024,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cfs_burst.sv
module cfs_burst #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11
) (
  input  logic             fill_mode,
  input  logic             drain_mode,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] rsp_cnt,
  input  logic [CNT_W-1:0] rd_pos,
  output logic [15:0]      burst
);
  generate
    if (CNT_W <= 16) begin : g_narrow
      logic [15:0] free_b, left_b;
      assign free_b = 16'(DEPTH) - 16'(wr_cnt);
      assign left_b = 16'(rsp_cnt) - 16'(rd_pos);
      assign burst  = fill_mode ? free_b : (drain_mode ? left_b : 16'd0);
    end else begin : g_wide
      logic [31:0] raw;
      assign raw   = fill_mode  ? (32'(DEPTH) - 32'(wr_cnt)) :
                     drain_mode ? (32'(rsp_cnt) - 32'(rd_pos)) : 32'd0;
      assign burst = (raw > 32'h0000_FFFF) ? 16'hFFFF : raw[15:0];
    end
  endgenerate

endmodule

// File: rtl/cmd_fifo_status_ctrl.sv
module cmd_fifo_status_ctrl #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 12,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              exec_busy,
  output logic [31:0]       exec_cmd_len,
  input  logic [IDX_W-1:0]  exec_rd_idx,
  output logic [7:0]        exec_rd_data,
  input  logic              rsp_we,
  input  logic [7:0]        rsp_byte,
  input  logic              exec_done
);
  import cfs_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // state
  cfs_state_e       state_q, state_d;
  logic [CNT_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] rsp_len_q, rsp_len_d;
  logic             wr_ptr_en, rd_ptr_en, rsp_len_en;

  // access decode
  logic sts_wr, fifo_wr, fifo_rd;
  logic ready_cmd, go_cmd, retry_cmd;
  logic wr_accept, rsp_accept, rd_accept;
  logic in_fill, expect_more, expect_flag, data_avail;
  logic [31:0] cmd_len;
  logic [15:0] burst;
  logic [7:0]  buf_rdata;
  logic        buf_we;
  logic [IDX_W-1:0] buf_waddr, buf_raddr;
  logic [7:0]  buf_wdata;

  assign sts_wr  = bus_en &&  bus_we && (bus_addr == ADDR_W'(OFF_STATUS));
  assign fifo_wr = bus_en &&  bus_we && (bus_addr == ADDR_W'(OFF_FIFO));
  assign fifo_rd = bus_en && !bus_we && (bus_addr == ADDR_W'(OFF_FIFO));

  assign in_fill     = (state_q == ST_READY) || (state_q == ST_RECV);
  assign expect_flag = in_fill && expect_more;
  assign data_avail  = (state_q == ST_DONE) && (rd_ptr_q < rsp_len_q);

  // priority inside one status write: ready, then go, then retry
  assign ready_cmd = sts_wr && bus_wdata[B_READY] && (state_q != ST_EXEC);
  assign go_cmd    = sts_wr && bus_wdata[B_GO] && !ready_cmd &&
                     (state_q == ST_RECV) && !expect_more;
  assign retry_cmd = sts_wr && bus_wdata[B_RETRY] && !ready_cmd &&
                     (state_q == ST_DONE);

  assign wr_accept  = fifo_wr && expect_flag && (wr_ptr_q < CNT_W'(DEPTH));
  assign rsp_accept = (state_q == ST_EXEC) && rsp_we && (rsp_len_q < CNT_W'(DEPTH));
  assign rd_accept  = fifo_rd && data_avail;

  // next state
  always_comb begin
    state_d   = state_q;
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    rsp_len_d = rsp_len_q;
    if (ready_cmd) begin
      state_d   = ST_READY;
      wr_ptr_d  = '0;
      rd_ptr_d  = '0;
      rsp_len_d = '0;
    end else if (go_cmd) begin
      state_d   = ST_EXEC;
      rd_ptr_d  = '0;
      rsp_len_d = '0;
    end else begin
      unique case (state_q)
        ST_READY, ST_RECV: begin
          if (wr_accept) begin
            wr_ptr_d = wr_ptr_q + 1'b1;
            state_d  = ST_RECV;
          end
        end
        ST_EXEC: begin
          if (rsp_accept) rsp_len_d = rsp_len_q + 1'b1;
          if (exec_done) begin
            state_d  = ST_DONE;
            rd_ptr_d = '0;
          end
        end
        ST_DONE: begin
          if (retry_cmd)      rd_ptr_d = '0;
          else if (rd_accept) rd_ptr_d = rd_ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign wr_ptr_en  = ready_cmd | wr_accept;
  assign rd_ptr_en  = ready_cmd | go_cmd | retry_cmd | rd_accept |
                      ((state_q == ST_EXEC) & exec_done);
  assign rsp_len_en = ready_cmd | go_cmd | rsp_accept;

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_IDLE;
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      rsp_len_q <= '0;
    end else begin
      state_q <= state_d;
      if (wr_ptr_en)  wr_ptr_q  <= wr_ptr_d;
      if (rd_ptr_en)  rd_ptr_q  <= rd_ptr_d;
      if (rsp_len_en) rsp_len_q <= rsp_len_d;
    end
  end

  // length field and expect flag
  cfs_len_track #(.CNT_W(CNT_W)) u_len (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr        (ready_cmd),
    .byte_we    (wr_accept),
    .byte_cnt   (wr_ptr_q),
    .byte_data  (bus_wdata),
    .cmd_len    (cmd_len),
    .expect_more(expect_more)
  );

  // shared command / response storage
  assign buf_we    = wr_accept | rsp_accept;
  assign buf_waddr = wr_accept ? wr_ptr_q[IDX_W-1:0] : rsp_len_q[IDX_W-1:0];
  assign buf_wdata = wr_accept ? bus_wdata : rsp_byte;
  assign buf_raddr = (state_q == ST_EXEC) ? exec_rd_idx : rd_ptr_q[IDX_W-1:0];

  cfs_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk  (clk),
    .we   (buf_we),
    .waddr(buf_waddr),
    .wdata(buf_wdata),
    .raddr(buf_raddr),
    .rdata(buf_rdata)
  );

  // burst count
  cfs_burst #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_burst (
    .fill_mode (expect_flag),
    .drain_mode(state_q == ST_DONE),
    .wr_cnt    (wr_ptr_q),
    .rsp_cnt   (rsp_len_q),
    .rd_pos    (rd_ptr_q),
    .burst     (burst)
  );

  // read mux
  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_W'(OFF_STATUS)) begin
      bus_rdata[B_VALID]  = (state_q != ST_EXEC);
      bus_rdata[B_READY]  = (state_q == ST_READY);
      bus_rdata[B_DATA]   = data_avail;
      bus_rdata[B_EXPECT] = expect_flag;
    end else if (bus_addr == ADDR_W'(OFF_BURST_LO)) begin
      bus_rdata = burst[7:0];
    end else if (bus_addr == ADDR_W'(OFF_BURST_HI)) begin
      bus_rdata = burst[15:8];
    end else if (bus_addr == ADDR_W'(OFF_FIFO)) begin
      bus_rdata = data_avail ? buf_rdata : 8'h00;
    end
  end

  assign exec_busy    = (state_q == ST_EXEC);
  assign exec_cmd_len = cmd_len;
  assign exec_rd_data = buf_rdata;

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_ready,
  input logic              wd_go,
  input logic              wd_retry,
  input logic              rd_valid_bit,
  input logic              exec_busy,
  input logic              exec_done,
  input cfs_pkg::cfs_state_e state_q,
  input logic [CNT_W-1:0]  wr_ptr_q,
  input logic [CNT_W-1:0]  rd_ptr_q,
  input logic [CNT_W-1:0]  rsp_len_q,
  input logic              expect_more
);
  import cfs_pkg::*;

  logic sts_wr, fifo_wr;
  assign sts_wr  = bus_en && bus_we && (bus_addr == ADDR_W'(OFF_STATUS));
  assign fifo_wr = bus_en && bus_we && (bus_addr == ADDR_W'(OFF_FIFO));

  p_busy_hides_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_busy && bus_addr == ADDR_W'(OFF_STATUS)) |-> !rd_valid_bit);

  p_exec_keeps_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_busy && !exec_done && sts_wr) |=> exec_busy);

  p_drop_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !(state_q inside {ST_READY, ST_RECV})) |=> $stable(wr_ptr_q));

  p_go_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wd_go && !wd_ready && state_q == ST_RECV && !expect_more) |=> exec_busy);

  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_busy && exec_done) |=> (state_q == ST_DONE && rd_ptr_q == '0));

  p_rd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_q <= rsp_len_q);

  p_retry_rewinds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wd_retry && !wd_ready && state_q == ST_DONE) |=> rd_ptr_q == '0);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_q <= CNT_W'(DEPTH)) && (rsp_len_q <= CNT_W'(DEPTH)));

endmodule

bind cmd_fifo_status_ctrl cfs_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .wd_ready    (bus_wdata[6]),
  .wd_go       (bus_wdata[5]),
  .wd_retry    (bus_wdata[1]),
  .rd_valid_bit(bus_rdata[7]),
  .exec_busy   (exec_busy),
  .exec_done   (exec_done),
  .state_q     (state_q),
  .wr_ptr_q    (wr_ptr_q),
  .rd_ptr_q    (rd_ptr_q),
  .rsp_len_q   (rsp_len_q),
  .expect_more (expect_more)
);

// File: tb/cmd_fifo_status_ctrl_test.sv
module cmd_fifo_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam logic [11:0] A_STS = 12'h018, A_BLO = 12'h019, A_BHI = 12'h01A,
                          A_FIFO = 12'h024;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        exec_busy;
  logic [31:0] exec_cmd_len;
  logic [9:0]  exec_rd_idx;
  logic [7:0]  exec_rd_data;
  logic        rsp_we, exec_done;
  logic [7:0]  rsp_byte;

  cmd_fifo_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .exec_busy(exec_busy), .exec_cmd_len(exec_cmd_len),
    .exec_rd_idx(exec_rd_idx), .exec_rd_data(exec_rd_data),
    .rsp_we(rsp_we), .rsp_byte(rsp_byte), .exec_done(exec_done)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] last_rd;

  // behavioural reference model
  int         m_st = 0;  // 0 idle 1 ready 2 recv 3 exec 4 done
  logic [7:0] cmdq[$];
  logic [7:0] rspq[$];
  int         m_rdp = 0;

  function automatic logic [31:0] m_len();
    if (cmdq.size() < 6) return 32'd0;
    return {cmdq[2], cmdq[3], cmdq[4], cmdq[5]};
  endfunction

  function automatic bit m_exp();
    if (!(m_st == 1 || m_st == 2)) return 1'b0;
    return !(cmdq.size() >= 6 && 32'(cmdq.size()) >= m_len());
  endfunction

  function automatic bit m_avail();
    return (m_st == 4) && (m_rdp < rspq.size());
  endfunction

  function automatic logic [15:0] m_burst();
    int v;
    v = 0;
    if (m_exp()) v = DEPTH - cmdq.size();
    else if (m_st == 4) v = rspq.size() - m_rdp;
    if (v > 65535) v = 65535;
    return 16'(v);
  endfunction

  function automatic logic [7:0] m_rdata(logic [11:0] a);
    logic [15:0] b;
    b = m_burst();
    case (a)
      A_STS:  return {m_st != 3, m_st == 1, 1'b0, m_avail(), m_exp(), 3'b000};
      A_BLO:  return b[7:0];
      A_BHI:  return b[15:8];
      A_FIFO: return m_avail() ? rspq[m_rdp] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_apply(bit en, bit we, logic [11:0] a, logic [7:0] wd,
                         bit rwe, logic [7:0] rb, bit done);
    int st0;
    st0 = m_st;
    if (en && we && a == A_STS) begin
      if (wd[6] && m_st != 3) begin
        m_st = 1; cmdq.delete(); rspq.delete(); m_rdp = 0;
      end else if (wd[5] && m_st == 2 && !m_exp()) begin
        m_st = 3; rspq.delete(); m_rdp = 0;
      end else if (wd[1] && m_st == 4) begin
        m_rdp = 0;
      end
    end else if (en && we && a == A_FIFO) begin
      if (m_exp() && cmdq.size() < DEPTH) begin
        cmdq.push_back(wd); m_st = 2;
      end
    end else if (en && !we && a == A_FIFO) begin
      if (m_avail()) m_rdp++;
    end
    if (st0 == 3 && m_st == 3) begin
      if (rwe && rspq.size() < DEPTH) rspq.push_back(rb);
      if (done) begin m_st = 4; m_rdp = 0; end
    end
  endtask

  // one clock: drive, compare against the model, update the model
  task automatic step(bit en, bit we, logic [11:0] a, logic [7:0] wd,
                      bit rwe = 0, logic [7:0] rb = 0, bit done = 0,
                      logic [9:0] idx = 0);
    logic [7:0] e;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
    rsp_we = rwe; rsp_byte = rb; exec_done = done; exec_rd_idx = idx;
    #1;
    e = m_rdata(a);
    last_rd = bus_rdata;
    chk(bus_rdata === e, (a == A_FIFO) ? "R8 fifo data" :
        (a == A_STS) ? "R2 status" : "R10 burst", int'(bus_rdata), int'(e));
    chk(exec_busy === (m_st == 3), "R6 exec_busy", int'(exec_busy), int'(m_st == 3));
    if (m_st == 3) begin
      chk(exec_cmd_len === m_len(), "R5 exec_cmd_len", int'(exec_cmd_len), int'(m_len()));
      if (rspq.size() == 0 && idx < cmdq.size())
        chk(exec_rd_data === cmdq[idx], "R7 exec_rd_data", int'(exec_rd_data), int'(cmdq[idx]));
    end
    @(posedge clk);
    m_apply(en, we, a, wd, rwe, rb, done);
  endtask

  task automatic probe(logic [11:0] a); step(0, 0, a, 8'h00); endtask
  task automatic wsts(logic [7:0] d);   step(1, 1, A_STS, d); endtask
  task automatic wfifo(logic [7:0] d);  step(1, 1, A_FIFO, d); endtask
  task automatic rfifo();               step(1, 0, A_FIFO, 8'h00); endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_en = 0; bus_we = 0; bus_addr = A_STS; bus_wdata = 0;
    rsp_we = 0; rsp_byte = 0; exec_done = 0; exec_rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) probe(A_STS);

    // R1 reset state
    probe(A_STS); chk(last_rd == 8'h80, "R1 status", last_rd, 8'h80);
    probe(A_BLO); chk(last_rd == 8'h00, "R1 burst lo", last_rd, 0);
    probe(A_BHI); chk(last_rd == 8'h00, "R1 burst hi", last_rd, 0);

    // R4 write in idle dropped
    wfifo(8'h55);
    probe(A_STS); chk(last_rd == 8'h80, "R4 idle drop", last_rd, 8'h80);

    // R3 ready; R10 burst = 1024
    wsts(8'h40);
    probe(A_STS); chk(last_rd == 8'hC8, "R3 ready status", last_rd, 8'hC8);
    probe(A_BHI); chk(last_rd == 8'h04, "R10 burst hi", last_rd, 8'h04);
    // R9 retry outside completion ignored
    wsts(8'h02);
    probe(A_STS); chk(last_rd == 8'hC8, "R9 retry ignored", last_rd, 8'hC8);

    // ten-byte command, length 0x0000000A
    wfifo(8'hC1);
    probe(A_STS); chk(last_rd == 8'h88, "R4 receiving", last_rd, 8'h88);
    wfifo(8'h01); wfifo(8'h00); wfifo(8'h00); wfifo(8'h00);
    wsts(8'h20);  // R6 go while expect set
    probe(A_STS); chk(last_rd == 8'h88, "R6 go ignored", last_rd, 8'h88);
    wfifo(8'h0A); wfifo(8'h11); wfifo(8'h22); wfifo(8'h33);
    probe(A_STS); chk(last_rd == 8'h88, "R5 still expecting", last_rd, 8'h88);
    wfifo(8'h44);
    probe(A_STS); chk(last_rd == 8'h80, "R5 expect cleared", last_rd, 8'h80);
    wfifo(8'h99);  // R4 dropped after length reached
    probe(A_BLO); chk(last_rd == 8'h00, "R4 burst zero", last_rd, 0);

    wsts(8'h20);
    probe(A_STS); chk(last_rd == 8'h00, "R6 exec status", last_rd, 0);
    chk(exec_cmd_len == 32'd10, "R5 length", int'(exec_cmd_len), 10);
    for (int i = 0; i < 10; i++) step(0, 0, A_STS, 8'h00, 0, 0, 0, 10'(i));
    step(0, 0, A_STS, 0, 0, 0, 0, 10'd9);
    chk(exec_rd_data == 8'h44, "R7 cmd byte 9", exec_rd_data, 8'h44);
    wsts(8'h40);  // R3 ignored while executing
    probe(A_STS); chk(last_rd == 8'h00, "R3 exec keeps", last_rd, 0);
    for (int i = 0; i < 7; i++) step(0, 0, A_STS, 8'h00, 1, 8'(8'hA0 + i), i == 6);
    probe(A_STS); chk(last_rd == 8'h90, "R7 completion", last_rd, 8'h90);
    probe(A_BLO); chk(last_rd == 8'h07, "R10 burst rsp", last_rd, 7);

    rfifo(); chk(last_rd == 8'hA0, "R8 byte0", last_rd, 8'hA0);
    rfifo(); rfifo();
    probe(A_BLO); chk(last_rd == 8'h04, "R8 burst left", last_rd, 4);
    wsts(8'h02);
    probe(A_BLO); chk(last_rd == 8'h07, "R9 rewind", last_rd, 7);
    for (int i = 0; i < 7; i++) rfifo();
    probe(A_STS); chk(last_rd == 8'h80, "R8 drained", last_rd, 8'h80);
    rfifo(); chk(last_rd == 8'h00, "R8 empty read", last_rd, 0);
    probe(12'h030); chk(last_rd == 8'h00, "R11 unmapped", last_rd, 0);

    // R6 priority: ready+go+retry together from completion
    wsts(8'h62);
    probe(A_STS); chk(last_rd == 8'hC8, "R6 priority", last_rd, 8'hC8);

    // R5 declared length below header size
    wfifo(8'h00); wfifo(8'h00); wfifo(8'h00); wfifo(8'h00); wfifo(8'h00);
    probe(A_STS); chk(last_rd == 8'h88, "R5 short hdr", last_rd, 8'h88);
    wfifo(8'h03);
    probe(A_STS); chk(last_rd == 8'h80, "R5 short done", last_rd, 8'h80);

    // R3 abort during reception
    wsts(8'h40); wfifo(8'h01); wfifo(8'h02); wsts(8'h40);
    probe(A_BHI); chk(last_rd == 8'h04, "R3 abort", last_rd, 8'h04);

    // R4/R10 length beyond buffer
    wfifo(8'h00); wfifo(8'h00); wfifo(8'h00); wfifo(8'h00);
    wfifo(8'h08); wfifo(8'h00);
    for (int i = 6; i < DEPTH; i++) wfifo(8'(i));
    wfifo(8'hEE);
    probe(A_STS); chk(last_rd == 8'h88, "R4 full expect", last_rd, 8'h88);
    probe(A_BLO); chk(last_rd == 8'h00, "R10 full burst", last_rd, 0);
    wsts(8'h20);
    probe(A_STS); chk(last_rd == 8'h88, "R6 go full", last_rd, 8'h88);

    // R8 empty response
    wsts(8'h40);
    for (int i = 0; i < 5; i++) wfifo(8'h00);
    wfifo(8'h06); wsts(8'h20);
    step(0, 0, A_STS, 8'h00, 0, 0, 1);
    probe(A_STS); chk(last_rd == 8'h80, "R8 no data", last_rd, 8'h80);
    probe(A_FIFO); chk(last_rd == 8'h00, "R11 probe", last_rd, 0);

    repeat (3) probe(A_STS);
    finish_run();
  end

endmodule